// File: doc/BRIEF.md
# Indirect Remapping FIFO

This block is a first-in first-out queue whose entries are not data words but short indices into a small table of values. When a value is pushed, every live table slot is compared with it at once. If a slot already holds that value, its index is queued and the slot's reference count goes up. Otherwise the lowest free slot is claimed, written with the value, and its index is queued. On the pop side, the index at the head of the queue selects a slot, and the slot's current contents are presented as the output data.

Values are changed only in the table, so a remap command (old value, new value) rewrites every live slot holding the old value in one cycle. Every queued occurrence of that value then pops as the new value. Because the queue still points at the same slots, a later remap of the new value acts on them again. A chain such as 5 to 6 followed by 6 to 7 therefore composes without any walk through the queue. A slot is reclaimed when its reference count returns to zero.

A remap takes effect in the cycle it is presented. Table lookups for a push in that cycle, and the value shown on the pop port in that cycle, both already see the rewritten table.

Top module: `remap_fifo`

## Requirements
- R1: After reset the queue is empty: `pop_valid` is 0 and `push_ready` is 1.
- R2: Without remaps, values pop in the order in which they were accepted on the push port (push accepted when `push_valid` and `push_ready` are both 1 at a rising clock edge; pop likewise with `pop_valid` and `pop_ready`).
- R3: A value equal to the value of a live slot reuses that slot, so sixteen pushes of one value are all accepted while only one slot is in use.
- R4: `push_ready` is 0 whenever the queue holds 16 entries, whatever the pushed value and whatever happens on the pop port.
- R5: With all 8 slots live, `push_ready` is 0 for a value that no slot holds and 1 for a value that some slot holds (queue not full).
- R6: A remap rewrites every live slot equal to `remap_old`, so every queued occurrence of that value later pops as `remap_new`.
- R7: Remaps compose: an entry pushed as 5, followed by remaps 5 to 6 and then 6 to 7, pops as 7.
- R8: When a remap and a push of the remap's old value occur in the same cycle, the pushed item is stored and later popped as the remap's new value.
- R9: When a remap occurs in the same cycle as a pop, `pop_data` in that cycle already shows the remapped value.
- R10: A slot whose reference count drops to zero through pops becomes free, so a value that no slot holds is accepted again.
- R11: When a remap makes two live slots hold the same value, a later remap of that value rewrites both slots.
- R12: A remap whose old value matches no live slot leaves every queued value unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | A value is offered on the push port |
| push_data | input | 8 | Value offered for queueing |
| push_ready | output | 1 | Push is accepted this cycle if valid |
| pop_valid | output | 1 | The queue holds at least one entry |
| pop_data | output | 8 | Current table value of the head entry |
| pop_ready | input | 1 | Consumer takes the head entry this cycle |
| remap_valid | input | 1 | Apply a remap this cycle |
| remap_old | input | 8 | Value to be replaced in the table |
| remap_new | input | 8 | Replacement value |

## Verification
The state that is hardest to reach from the ports is one where several live slots hold the same value. Only a remap onto a value that is already present can produce it, and it must then be followed by a push, a further remap or a pop while both slots are still live. The directed sequence builds this on purpose. The random phase draws values from a range of twelve against eight slots, with frequent remaps, so merged slots, a full table and the same-cycle remap cases with a push or a pop all recur many times. A reference model keyed by its own slot identities predicts every cycle's ready, valid and data.

// File: rtl/rfifo_pkg.sv
package rfifo_pkg;

  // Index of the lowest set bit of vec, or 64 when none is set.
  function automatic int unsigned first_set(input logic [63:0] vec);
    int unsigned pos;
    logic found;
    pos = 64;
    found = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (vec[i] && !found) begin
        pos = i;
        found = 1'b1;
      end
    end
    return pos;
  endfunction

endpackage

// File: rtl/rfifo_idxq.sv
module rfifo_idxq #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 3,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             rd_en,
  output logic [IDX_W-1:0] head_idx,
  output logic             empty,
  output logic             full,
  output logic [OCC_W-1:0] occ
);

  logic [IDX_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty    = (occ == '0);
  assign full     = (occ == OCC_W'(DEPTH));
  assign head_idx = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (wr_en) begin
        mem[wr_ptr] <= wr_idx;
        wr_ptr      <= ptr_next(wr_ptr);
      end
      if (rd_en) rd_ptr <= ptr_next(rd_ptr);
      occ <= occ + OCC_W'(wr_en) - OCC_W'(rd_en);
    end
  end

endmodule

// File: rtl/rfifo_table.sv
module rfifo_table
  import rfifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SLOTS  = 8,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     remap_valid,
  input  logic [DATA_W-1:0]        remap_old,
  input  logic [DATA_W-1:0]        remap_new,
  input  logic [DATA_W-1:0]        lookup_data,
  input  logic                     push_fire,
  input  logic                     pop_fire,
  input  logic [IDX_W-1:0]         pop_idx,
  output logic                     hit,
  output logic                     free_any,
  output logic [IDX_W-1:0]         push_idx,
  output logic [SLOTS-1:0]         slot_live,
  output logic [SLOTS*DATA_W-1:0]  eff_flat,
  output logic [SLOTS*DATA_W-1:0]  stored_flat
);

  logic [DATA_W-1:0] val_q [SLOTS];
  logic [CNT_W-1:0]  cnt_q [SLOTS];
  logic [SLOTS-1:0]  match_v, free_v, rewrite_v;
  logic [IDX_W-1:0]  hit_idx, free_idx;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [DATA_W-1:0] eff;
    logic              inc, dec, alloc;

    assign slot_live[s] = (cnt_q[s] != '0);
    assign rewrite_v[s] = remap_valid && slot_live[s] && (val_q[s] == remap_old);
    assign eff          = rewrite_v[s] ? remap_new : val_q[s];
    assign match_v[s]   = slot_live[s] && (eff == lookup_data);
    assign free_v[s]    = !slot_live[s];
    assign eff_flat[s*DATA_W +: DATA_W]    = eff;
    assign stored_flat[s*DATA_W +: DATA_W] = val_q[s];

    assign inc   = push_fire && (push_idx == IDX_W'(s));
    assign dec   = pop_fire && (pop_idx == IDX_W'(s));
    assign alloc = inc && !hit;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        val_q[s] <= '0;
        cnt_q[s] <= '0;
      end else begin
        val_q[s] <= alloc ? lookup_data : eff;
        cnt_q[s] <= cnt_q[s] + CNT_W'(inc) - CNT_W'(dec);
      end
    end
  end

  assign hit      = |match_v;
  assign free_any = |free_v;
  assign hit_idx  = IDX_W'(first_set(64'(match_v)));
  assign free_idx = IDX_W'(first_set(64'(free_v)));
  assign push_idx = hit ? hit_idx : free_idx;

endmodule

// File: rtl/remap_fifo.sv
module remap_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int SLOTS  = 8,
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  output logic              push_ready,
  output logic              pop_valid,
  output logic [DATA_W-1:0] pop_data,
  input  logic              pop_ready,
  input  logic              remap_valid,
  input  logic [DATA_W-1:0] remap_old,
  input  logic [DATA_W-1:0] remap_new
);

  logic [DATA_W-1:0]       push_eff;
  logic                    hit, free_any, push_fire, pop_fire, q_empty, q_full;
  logic [IDX_W-1:0]        push_idx, head_idx;
  logic [SLOTS-1:0]        slot_live;
  logic [SLOTS*DATA_W-1:0] eff_flat, stored_flat;
  logic [CNT_W-1:0]        occ;

  // A push of the value being remapped this cycle is taken as the new value.
  assign push_eff   = (remap_valid && (push_data == remap_old)) ? remap_new : push_data;
  assign push_ready = !q_full && (hit || free_any);
  assign push_fire  = push_valid && push_ready;
  assign pop_valid  = !q_empty;
  assign pop_fire   = pop_valid && pop_ready;
  assign pop_data   = eff_flat[head_idx*DATA_W +: DATA_W];

  rfifo_table #(
    .DATA_W(DATA_W), .SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_table (
    .clk         (clk),
    .rst_n       (rst_n),
    .remap_valid (remap_valid),
    .remap_old   (remap_old),
    .remap_new   (remap_new),
    .lookup_data (push_eff),
    .push_fire   (push_fire),
    .pop_fire    (pop_fire),
    .pop_idx     (head_idx),
    .hit         (hit),
    .free_any    (free_any),
    .push_idx    (push_idx),
    .slot_live   (slot_live),
    .eff_flat    (eff_flat),
    .stored_flat (stored_flat)
  );

  rfifo_idxq #(
    .DEPTH(DEPTH), .IDX_W(IDX_W)
  ) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (push_fire),
    .wr_idx   (push_idx),
    .rd_en    (pop_fire),
    .head_idx (head_idx),
    .empty    (q_empty),
    .full     (q_full),
    .occ      (occ)
  );

endmodule

// File: rtl/rfifo_chk.sv
module rfifo_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int SLOTS  = 8,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    push_valid,
  input logic                    push_ready,
  input logic                    pop_valid,
  input logic                    pop_ready,
  input logic                    remap_valid,
  input logic [DATA_W-1:0]       remap_old,
  input logic [DATA_W-1:0]       remap_new,
  input logic                    hit,
  input logic                    free_any,
  input logic [IDX_W-1:0]        head_idx,
  input logic [SLOTS-1:0]        slot_live,
  input logic [SLOTS*DATA_W-1:0] stored_flat,
  input logic [CNT_W-1:0]        occ
);

  logic [DATA_W-1:0] last_old_q;
  logic              last_rm_q;
  logic              old_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_old_q <= '0;
      last_rm_q  <= 1'b0;
    end else begin
      last_old_q <= remap_old;
      last_rm_q  <= remap_valid && (remap_old != remap_new);
    end
  end

  always_comb begin
    old_left = 1'b0;
    for (int s = 0; s < SLOTS; s++)
      if (slot_live[s] && (stored_flat[s*DATA_W +: DATA_W] == last_old_q)) old_left = 1'b1;
  end

  p_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !pop_valid);

  p_occ_grow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_ready && !(pop_valid && pop_ready)) |=> (occ == CNT_W'($past(occ) + 1'b1)));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CNT_W'(DEPTH)) |-> !push_ready);

  p_no_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !free_any) |-> !push_ready);

  p_old_gone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    last_rm_q |-> !old_left);

  p_head_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && pop_ready) |-> slot_live[head_idx]);

endmodule

bind remap_fifo rfifo_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .push_valid  (push_valid),
  .push_ready  (push_ready),
  .pop_valid   (pop_valid),
  .pop_ready   (pop_ready),
  .remap_valid (remap_valid),
  .remap_old   (remap_old),
  .remap_new   (remap_new),
  .hit         (hit),
  .free_any    (free_any),
  .head_idx    (head_idx),
  .slot_live   (slot_live),
  .stored_flat (stored_flat),
  .occ         (occ)
);

// File: tb/tb_remap_fifo.sv
module tb_remap_fifo;

  localparam int QD = 16;
  localparam int NS = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push_valid = 1'b0, pop_ready = 1'b0, remap_valid = 1'b0;
  logic [7:0] push_data = '0, remap_old = '0, remap_new = '0;
  logic       push_ready, pop_valid;
  logic [7:0] pop_data;

  int n_tests = 0;
  int n_fail  = 0;

  // Reference model: slots by the model's own identity, queue of slot tags.
  int m_val [NS];
  int m_cnt [NS];
  int mq    [QD];
  int mlen;

  always #4 clk = ~clk;

  remap_fifo dut (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
    .pop_valid(pop_valid), .pop_data(pop_data), .pop_ready(pop_ready),
    .remap_valid(remap_valid), .remap_old(remap_old), .remap_new(remap_new)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    push_valid = 1'b0; pop_ready = 1'b0; remap_valid = 1'b0;
    repeat (2) @(posedge clk);
    for (int s = 0; s < NS; s++) begin m_val[s] = 0; m_cnt[s] = 0; end
    mlen = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input bit pv, input int pd, input bit qr,
                      input bit rv, input int ro, input int rn, input string req);
    int ev [NS];
    int pe, hit, fr;
    bit exp_rdy, exp_pv;
    @(negedge clk);
    push_valid = pv; push_data = 8'(pd); pop_ready = qr;
    remap_valid = rv; remap_old = 8'(ro); remap_new = 8'(rn);
    #2;
    for (int s = 0; s < NS; s++)
      ev[s] = (rv && m_cnt[s] > 0 && m_val[s] == ro) ? rn : m_val[s];
    pe = (rv && pd == ro) ? rn : pd;
    hit = -1; fr = -1;
    for (int s = 0; s < NS; s++) begin
      if (hit < 0 && m_cnt[s] > 0 && ev[s] == pe) hit = s;
      if (fr < 0 && m_cnt[s] == 0) fr = s;
    end
    exp_rdy = (mlen < QD) && (hit >= 0 || fr >= 0);
    exp_pv  = (mlen > 0);
    check(req, "push_ready", int'(push_ready), int'(exp_rdy));
    check(req, "pop_valid", int'(pop_valid), int'(exp_pv));
    if (exp_pv) check(req, "pop_data", int'(pop_data), ev[mq[0]]);
    @(posedge clk);
    #1;
    for (int s = 0; s < NS; s++) m_val[s] = ev[s];
    if (qr && exp_pv) begin
      m_cnt[mq[0]]--;
      for (int i = 0; i < QD - 1; i++) mq[i] = mq[i+1];
      mlen--;
    end
    if (pv && exp_rdy) begin
      int t;
      t = (hit >= 0) ? hit : fr;
      if (hit < 0) m_val[t] = pe;
      m_cnt[t]++;
      mq[mlen] = t;
      mlen++;
    end
  endtask

  task automatic push_v(input int v, input string req);
    step(1'b1, v, 1'b0, 1'b0, 0, 0, req);
  endtask

  task automatic pop_one(input string req);
    step(1'b0, 0, 1'b1, 1'b0, 0, 0, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    do_reset();

    // R1: idle state after reset
    step(1'b0, 0, 1'b0, 1'b0, 0, 0, "R1");

    // R2: order preserved
    push_v(1, "R2"); push_v(2, "R2"); push_v(3, "R2");
    repeat (3) pop_one("R2");

    // R3 / R4: one value fills the whole queue via one slot, then full
    do_reset();
    repeat (QD) push_v(9, "R3");
    push_v(9, "R4");
    push_v(4, "R4");
    step(1'b1, 9, 1'b1, 1'b0, 0, 0, "R4");
    repeat (QD) pop_one("R3");

    // R5 / R10: table exhaustion and reclamation
    do_reset();
    for (int v = 0; v < NS; v++) push_v(v + 20, "R5");
    push_v(50, "R5");
    push_v(23, "R5");
    pop_one("R10");
    push_v(50, "R10");
    repeat (NS + 1) pop_one("R10");

    // R6 / R7 / R11: merge by remap, then chained remap over both slots
    do_reset();
    push_v(5, "R6"); push_v(6, "R6"); push_v(5, "R6"); push_v(9, "R6");
    step(1'b0, 0, 1'b0, 1'b1, 5, 6, "R6");
    step(1'b0, 0, 1'b0, 1'b1, 6, 7, "R7 R11");
    repeat (4) pop_one("R7 R11");

    // R8: remap and push of its old value together
    do_reset();
    push_v(5, "R8");
    step(1'b1, 5, 1'b0, 1'b1, 5, 6, "R8");
    repeat (2) pop_one("R8");

    // R9 / R12: remap during pop; remap without a match
    do_reset();
    push_v(4, "R9"); push_v(4, "R9");
    step(1'b0, 0, 1'b1, 1'b1, 4, 2, "R9");
    step(1'b0, 0, 1'b0, 1'b1, 40, 41, "R12");
    pop_one("R12");

    // Random mix
    do_reset();
    for (int k = 0; k < 3000; k++) begin
      bit pv, qr, rv;
      int pd, ro, rn;
      pv = ($urandom % 3) != 0;
      qr = ($urandom % 2) != 0;
      rv = ($urandom % 6) == 0;
      pd = $urandom % 12;
      ro = $urandom % 12;
      rn = $urandom % 12;
      step(pv, pd, qr, rv, ro, rn, "RND");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule